// File: doc/BRIEF.md
# AHB-Lite Burst Address Sequencer

This block is the address side of a single bus master. A client hands it one command at a time: a start address, a transfer size, a burst type, a direction and, for open-ended incrementing bursts, a beat count. The block turns the command into a run of AHB-Lite address phases on HADDR, HTRANS, HSIZE, HBURST and HWRITE. It moves on only when HREADY is high, so a slave's wait states freeze the phase in progress. A separate "master not ready" input lets the client stall a burst between beats with BUSY phases.

Every output comes from a register. A command is taken only while the block is idle and HREADY is high. Its first address phase appears in the cycle after the command is accepted. Once the last beat completes, the block drives IDLE for at least one cycle. Wrapping bursts stay inside a window of beat count times transfer size. Incrementing bursts never carry a SEQ beat across a 1KB line. A fixed-length incrementing burst that would cross such a line is sent as an undefined-length burst instead, and it restarts with a NONSEQ beat at the line.

Top module: `ahb_burst_seq`

## Requirements
- R1: After reset, and whenever no command is in progress, htrans is IDLE (2'b00) and cmd_ready equals hready. busy_req has no effect while idle.
- R2: An accepted command shows up in the next cycle as a NONSEQ (2'b10) phase. Its haddr is cmd_addr with the low log2(bytes) bits cleared, and hwrite and hburst come from the command. htrans never goes from IDLE straight to anything but NONSEQ.
- R3: In an incrementing burst, each SEQ (2'b11) beat's address is the previous beat's address plus 2^hsize bytes.
- R4: Beat count follows cmd_burst: SINGLE=000 gives 1, INCR=001 gives cmd_beats (0 is treated as 1), WRAP4=010 and INCR4=011 give 4, WRAP8=100 and INCR8=101 give 8, WRAP16=110 and INCR16=111 give 16. After the last beat completes, htrans returns to IDLE.
- R5: A wrapping burst keeps every address inside an aligned window of beats x 2^size bytes and wraps to the window's base. A word WRAP4 from 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R6: hsize stays the same on every beat of a burst. A cmd_size above the data bus width (above 2 for 32 bits) is clamped to 2.
- R7: While hready is low, haddr, htrans, hsize, hburst and hwrite keep their values into the next cycle.
- R8: With busy_req high when a non-final beat completes, the block drives BUSY (2'b01) with the next beat's address. It holds BUSY while busy_req stays high, then sends that address as SEQ. BUSY never follows IDLE directly.
- R9: When an undefined-length INCR burst steps onto a 1KB line (address bits [9:0] all zero), that beat is NONSEQ instead of SEQ, and no BUSY is placed in front of it.
- R10: A fixed INCR4/8/16 whose span would pass a 1KB line is driven with hburst=INCR (001), restarting with NONSEQ at the line. The addresses and beat count do not change.
- R11: cmd_ready is low whenever a burst is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken at this edge when cmd_valid is high |
| cmd_addr | input | 32 | Start address |
| cmd_size | input | 3 | log2 of bytes per beat |
| cmd_burst | input | 3 | Burst type, encoded as in R4 |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_beats | input | BEAT_W | Beat count for undefined-length INCR |
| busy_req | input | 1 | Master not ready; asks for BUSY between beats |
| hready | input | 1 | Previous transfer complete |
| haddr | output | 32 | Address phase address |
| htrans | output | 2 | Transfer type |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type |
| hwrite | output | 1 | Transfer direction |

## Verification
The hardest case to reach is a BUSY phase or a slave wait that lands right around a 1KB restart or a wrap point. In that case the address shown during the stall has to be the next beat's, already wrapped or already on the new line. The bench gets there by running bursts that start a few beats below a 1KB line, plus wrapping bursts, while a background process toggles hready and busy_req on random cycles. A scoreboard predicts every beat on its own terms. During each BUSY it checks that haddr equals the beat at the head of its queue, and after each cycle with hready low it checks that the outputs did not change.

// File: rtl/ahb_seq_pkg.sv
package ahb_seq_pkg;

    localparam int ADDR_W  = 32;
    localparam int KB_BITS = 10;
    localparam int SPAN_W  = 12;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        BT_SINGLE = 3'b000,
        BT_INCR   = 3'b001,
        BT_WRAP4  = 3'b010,
        BT_INCR4  = 3'b011,
        BT_WRAP8  = 3'b100,
        BT_INCR8  = 3'b101,
        BT_WRAP16 = 3'b110,
        BT_INCR16 = 3'b111
    } burst_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [2:0]        size;
        burst_e            burst;
        logic              write;
    } phase_t;

    // Fixed beat count of a burst type; 0 for the open-ended type
    function automatic logic [4:0] fixed_beats(burst_e b);
        case (b)
            BT_SINGLE:           return 5'd1;
            BT_WRAP4, BT_INCR4:   return 5'd4;
            BT_WRAP8, BT_INCR8:   return 5'd8;
            BT_WRAP16, BT_INCR16: return 5'd16;
            default:             return 5'd0;
        endcase
    endfunction

    function automatic logic is_wrap(burst_e b);
        return (b == BT_WRAP4) || (b == BT_WRAP8) || (b == BT_WRAP16);
    endfunction

    function automatic logic is_fixed_incr(burst_e b);
        return (b == BT_INCR4) || (b == BT_INCR8) || (b == BT_INCR16);
    endfunction

endpackage

// File: rtl/ahb_cmd_decode.sv
module ahb_cmd_decode
    import ahb_seq_pkg::*;
#(
    parameter int BEAT_W   = 8,
    parameter int MAX_SIZE = 2
) (
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [2:0]        cmd_size,
    input  logic [2:0]        cmd_burst,
    input  logic [BEAT_W-1:0] cmd_beats,
    input  logic              cmd_write,
    output phase_t            first_phase,
    output logic [BEAT_W-1:0] total_beats,
    output logic [SPAN_W-1:0] wrap_mask
);

    burst_e              req_burst;
    logic [2:0]          eff_size;
    logic [ADDR_W-1:0]   lane_mask;
    logic [ADDR_W-1:0]   start_addr;
    logic [4:0]          fixed_n;
    logic [SPAN_W-1:0]   span;
    logic [SPAN_W:0]     reach;
    logic                passes_line;

    always_comb begin
        req_burst   = burst_e'(cmd_burst);
        eff_size    = (cmd_size > 3'(MAX_SIZE)) ? 3'(MAX_SIZE) : cmd_size;
        lane_mask   = (ADDR_W'(1) << eff_size) - ADDR_W'(1);
        start_addr  = cmd_addr & ~lane_mask;
        fixed_n     = fixed_beats(req_burst);
        span        = SPAN_W'(fixed_n) << eff_size;

        if (req_burst == BT_INCR)
            total_beats = (cmd_beats == '0) ? BEAT_W'(1) : cmd_beats;
        else
            total_beats = BEAT_W'(fixed_n);

        // End offset of the burst within its 1KB line
        reach       = {1'b0, SPAN_W'(start_addr[KB_BITS-1:0])} + {1'b0, span};
        passes_line = is_fixed_incr(req_burst) &&
                      (reach > (SPAN_W+1)'(1 << KB_BITS));

        wrap_mask   = is_wrap(req_burst) ? (span - SPAN_W'(1)) : '0;

        first_phase.addr  = start_addr;
        first_phase.size  = eff_size;
        first_phase.burst = passes_line ? BT_INCR : req_burst;
        first_phase.write = cmd_write;
    end

endmodule

// File: rtl/ahb_addr_step.sv
module ahb_addr_step
    import ahb_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [2:0]        size,
    input  logic [SPAN_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] next_addr,
    output logic              on_line
);

    logic [ADDR_W-1:0] bumped;
    logic [ADDR_W-1:0] window;

    always_comb begin
        bumped = cur_addr + (ADDR_W'(1) << size);
        window = ADDR_W'(wrap_mask);
        if (wrap_mask != '0) begin
            next_addr = (cur_addr & ~window) | (bumped & window);
            on_line   = 1'b0;
        end else begin
            next_addr = bumped;
            on_line   = (bumped[KB_BITS-1:0] == '0);
        end
    end

endmodule

// File: rtl/ahb_burst_seq.sv
module ahb_burst_seq
    import ahb_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [31:0]       cmd_addr,
    input  logic [2:0]        cmd_size,
    input  logic [2:0]        cmd_burst,
    input  logic              cmd_write,
    input  logic [BEAT_W-1:0] cmd_beats,
    input  logic              busy_req,
    input  logic              hready,
    output logic [31:0]       haddr,
    output logic [1:0]        htrans,
    output logic [2:0]        hsize,
    output logic [2:0]        hburst,
    output logic              hwrite
);

    localparam int MAX_SIZE = $clog2(DATA_W / 8);

    phase_t              ph_q;
    trans_e              trans_q;
    logic                act_q;
    logic [BEAT_W-1:0]   rem_q;
    logic [SPAN_W-1:0]   wmask_q;

    phase_t              dec_phase;
    logic [BEAT_W-1:0]   dec_beats;
    logic [SPAN_W-1:0]   dec_wmask;
    logic [ADDR_W-1:0]   step_addr;
    logic                step_line;
    logic                beat_done;

    ahb_cmd_decode #(
        .BEAT_W   (BEAT_W),
        .MAX_SIZE (MAX_SIZE)
    ) u_decode (
        .cmd_addr    (cmd_addr),
        .cmd_size    (cmd_size),
        .cmd_burst   (cmd_burst),
        .cmd_beats   (cmd_beats),
        .cmd_write   (cmd_write),
        .first_phase (dec_phase),
        .total_beats (dec_beats),
        .wrap_mask   (dec_wmask)
    );

    ahb_addr_step u_step (
        .cur_addr  (ph_q.addr),
        .size      (ph_q.size),
        .wrap_mask (wmask_q),
        .next_addr (step_addr),
        .on_line   (step_line)
    );

    assign cmd_ready = !act_q && hready;
    assign beat_done = hready && ((trans_q == TR_NONSEQ) || (trans_q == TR_SEQ));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            trans_q  <= TR_IDLE;
            ph_q     <= '{addr: '0, size: 3'd0, burst: BT_SINGLE, write: 1'b0};
            rem_q    <= '0;
            wmask_q  <= '0;
        end else if (hready) begin
            if (!act_q) begin
                if (cmd_valid) begin
                    act_q   <= 1'b1;
                    trans_q <= TR_NONSEQ;
                    ph_q    <= dec_phase;
                    rem_q   <= dec_beats;
                    wmask_q <= dec_wmask;
                end
            end else if (beat_done) begin
                if (rem_q == BEAT_W'(1)) begin
                    act_q   <= 1'b0;
                    trans_q <= TR_IDLE;
                end else begin
                    rem_q     <= rem_q - BEAT_W'(1);
                    ph_q.addr <= step_addr;
                    if (step_line)
                        trans_q <= TR_NONSEQ;
                    else if (busy_req)
                        trans_q <= TR_BUSY;
                    else
                        trans_q <= TR_SEQ;
                end
            end else if ((trans_q == TR_BUSY) && !busy_req) begin
                trans_q <= TR_SEQ;
            end
        end
    end

    assign haddr  = ph_q.addr;
    assign htrans = trans_q;
    assign hsize  = ph_q.size;
    assign hburst = ph_q.burst;
    assign hwrite = ph_q.write;

endmodule

// File: rtl/ahb_burst_seq_chk.sv
module ahb_burst_seq_chk #(
    parameter int MAX_SIZE = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        hready,
    input logic        cmd_ready,
    input logic [31:0] haddr,
    input logic [1:0]  htrans,
    input logic [2:0]  hsize,
    input logic [2:0]  hburst,
    input logic        hwrite
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R2
    first_nonseq_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(htrans) == 2'b00 && htrans != 2'b00) |-> htrans == 2'b10);

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && htrans == 2'b11 && hburst[0] && $past(hready) && $past(htrans[1]))
        |-> haddr == $past(haddr) + (32'd1 << hsize));

    // R6
    size_cap_chk: assert property (@(posedge clk) disable iff (rst)
        htrans != 2'b00 |-> hsize <= 3'(MAX_SIZE));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(hready)) |->
        ($stable(haddr) && $stable(htrans) && $stable(hsize) && $stable(hburst) && $stable(hwrite)));

    // R8
    busy_inside_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && htrans == 2'b01) |-> $past(htrans) != 2'b00);

    // R8
    busy_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(htrans) == 2'b01 && htrans == 2'b11) |-> $stable(haddr));

    // R9
    line_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b11 && hburst[0]) |-> haddr[9:0] != 10'd0);

    // R11
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> htrans == 2'b00);

endmodule

bind ahb_burst_seq ahb_burst_seq_chk #(.MAX_SIZE(MAX_SIZE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hready    (hready),
    .cmd_ready (cmd_ready),
    .haddr     (haddr),
    .htrans    (htrans),
    .hsize     (hsize),
    .hburst    (hburst),
    .hwrite    (hwrite)
);

// File: tb/ahb_burst_seq_test.sv
module ahb_burst_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [2:0]  cmd_size = '0;
    logic [2:0]  cmd_burst = '0;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_beats = '0;
    logic        busy_req = 1'b0;
    logic        hready = 1'b1;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic [2:0]  hsize;
    logic [2:0]  hburst;
    logic        hwrite;

    int tests = 0;
    int fails = 0;
    bit wait_mode = 0;
    bit busy_mode = 0;
    bit busy_force = 0;
    int busy_seen = 0;

    logic [31:0] q_addr[$];
    logic [1:0]  q_trans[$];
    logic [2:0]  q_burst[$];
    logic [2:0]  q_size[$];
    logic        q_write[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    ahb_burst_seq uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_burst(cmd_burst),
        .cmd_write(cmd_write), .cmd_beats(cmd_beats), .busy_req(busy_req),
        .hready(hready), .haddr(haddr), .htrans(htrans), .hsize(hsize),
        .hburst(hburst), .hwrite(hwrite)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    // Predicted beats from the requirements
    task automatic predict(input logic [31:0] a, input logic [2:0] s, input logic [2:0] b,
                           input logic w, input logic [7:0] n, input string tag);
        logic [2:0]  es;
        logic [31:0] by, st, span, ad;
        int          cnt;
        bit          wr, dem;
        es   = (s > 3'd2) ? 3'd2 : s;
        by   = 32'd1 << es;
        st   = a & ~(by - 1);
        case (b)
            3'b000: cnt = 1;
            3'b001: cnt = (n == 0) ? 1 : int'(n);
            3'b010, 3'b011: cnt = 4;
            3'b100, 3'b101: cnt = 8;
            default: cnt = 16;
        endcase
        wr   = (b == 3'b010) || (b == 3'b100) || (b == 3'b110);
        span = 32'(cnt) * by;
        dem  = ((b == 3'b011) || (b == 3'b101) || (b == 3'b111)) &&
               ((st & 32'h3FF) + span > 32'd1024);
        for (int i = 0; i < cnt; i++) begin
            if (wr) ad = (st & ~(span - 1)) | ((st + 32'(i) * by) & (span - 1));
            else    ad = st + 32'(i) * by;
            q_addr.push_back(ad);
            q_trans.push_back((i == 0 || (!wr && ad[9:0] == 0)) ? 2'b10 : 2'b11);
            q_burst.push_back(dem ? 3'b001 : b);
            q_size.push_back(es);
            q_write.push_back(w);
            q_tag.push_back(tag);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [2:0] s, input logic [2:0] b,
                        input logic w, input logic [7:0] n, input string tag);
        predict(a, s, b, w, n, tag);
        do begin @(posedge clk); #2; end while (!cmd_ready);
        cmd_addr = a; cmd_size = s; cmd_burst = b; cmd_write = w; cmd_beats = n;
        cmd_valid = 1'b1;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (q_addr.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(htrans == 2'b00, "R4", $sformatf("idle after burst: htrans=%0d expected 0", htrans));
    endtask

    // Input pattern driver: hready and busy_req change just after the edge
    initial begin
        forever begin
            @(posedge clk); #1;
            hready   = wait_mode ? ($urandom % 3 != 0) : 1'b1;
            busy_req = busy_force ? 1'b1 : (busy_mode ? ($urandom % 2 == 0) : 1'b0);
        end
    end

    // Monitor / scoreboard
    initial begin
        bit          armed = 0;
        logic [31:0] h_a;
        logic [1:0]  h_t;
        logic [2:0]  h_s, h_b;
        logic        h_w;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (armed)
                    check(haddr == h_a && htrans == h_t && hsize == h_s && hburst == h_b && hwrite == h_w,
                          "R7", $sformatf("hold: addr=%h trans=%0d expected addr=%h trans=%0d",
                                          haddr, htrans, h_a, h_t));
                armed = !hready;
                h_a = haddr; h_t = htrans; h_s = hsize; h_b = hburst; h_w = hwrite;
                if (htrans == 2'b01) begin
                    busy_seen++;
                    if (q_addr.size() == 0)
                        check(0, "R8", "BUSY with no beat pending: actual busy expected none");
                    else
                        check(haddr == q_addr[0], "R8",
                              $sformatf("busy addr=%h expected %h", haddr, q_addr[0]));
                end
                if (hready && htrans[1]) begin
                    if (q_addr.size() == 0) begin
                        check(0, "R4", $sformatf("extra beat addr=%h expected none", haddr));
                    end else begin
                        check(haddr == q_addr[0] && htrans == q_trans[0] && hburst == q_burst[0] &&
                              hsize == q_size[0] && hwrite == q_write[0], q_tag[0],
                              $sformatf("beat addr=%h trans=%0d burst=%0d size=%0d wr=%0d expected addr=%h trans=%0d burst=%0d size=%0d wr=%0d",
                                        haddr, htrans, hburst, hsize, hwrite,
                                        q_addr[0], q_trans[0], q_burst[0], q_size[0], q_write[0]));
                        void'(q_addr.pop_front()); void'(q_trans.pop_front());
                        void'(q_burst.pop_front()); void'(q_size.pop_front());
                        void'(q_write.pop_front()); void'(q_tag.pop_front());
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(htrans == 2'b00, "R1", $sformatf("reset htrans=%0d expected 0", htrans));
        check(cmd_ready == 1'b1, "R1", $sformatf("reset cmd_ready=%0d expected 1", cmd_ready));

        // R1 / R8: busy_req while idle changes nothing
        busy_force = 1;
        repeat (5) @(negedge clk);
        check(htrans == 2'b00, "R1", $sformatf("idle with busy_req htrans=%0d expected 0", htrans));
        busy_force = 0;
        repeat (2) @(negedge clk);

        // R2 single, unaligned start gets aligned
        send(32'h0000_0103, 3'd2, 3'b000, 1'b1, 8'd0, "R2");
        drain();
        // R11: cmd_ready low while a burst runs
        send(32'h0000_0200, 3'd2, 3'b011, 1'b0, 8'd0, "R3");
        @(negedge clk);
        check(!(htrans != 2'b00 && cmd_ready), "R11",
              $sformatf("cmd_ready=%0d while htrans=%0d expected 0", cmd_ready, htrans));
        drain();
        // R5 wrapping bursts
        send(32'h0000_0034, 3'd2, 3'b010, 1'b1, 8'd0, "R5");
        drain();
        send(32'h0000_001A, 3'd1, 3'b100, 1'b0, 8'd0, "R5");
        drain();
        send(32'h0000_0087, 3'd0, 3'b110, 1'b1, 8'd0, "R5");
        drain();
        // R3 / R4 incrementing fixed bursts
        send(32'h0000_0500, 3'd1, 3'b101, 1'b1, 8'd0, "R3");
        drain();
        send(32'h0000_0610, 3'd0, 3'b111, 1'b0, 8'd0, "R4");
        drain();
        // R4 undefined length, zero count means one beat
        send(32'h0000_0700, 3'd2, 3'b001, 1'b1, 8'd0, "R4");
        drain();
        send(32'h0000_0720, 3'd2, 3'b001, 1'b1, 8'd5, "R4");
        drain();
        // R6 size clamp
        send(32'h0000_0800, 3'd3, 3'b011, 1'b0, 8'd0, "R6");
        drain();
        // R9 open-ended INCR across a 1KB line
        send(32'h0000_03F8, 3'd2, 3'b001, 1'b1, 8'd6, "R9");
        drain();
        // R10 fixed INCR8 that would pass a 1KB line
        send(32'h0000_0BF0, 3'd2, 3'b101, 1'b0, 8'd0, "R10");
        drain();

        // R7 / R8 with slave waits and master BUSY in the background
        wait_mode = 1;
        busy_mode = 1;
        for (int k = 0; k < 6; k++) begin
            send(32'h0000_0034 + 32'(k) * 32'h400, 3'd2, 3'b100, 1'b1, 8'd0, "R5");
            send(32'h0000_07F4 + 32'(k) * 32'h800, 3'd2, 3'b001, 1'b0, 8'd7, "R9");
            send(32'h0000_0FF8 + 32'(k) * 32'h800, 3'd1, 3'b111, 1'b1, 8'd0, "R10");
            send(32'h0000_0120 + 32'(k) * 32'h10, 3'd1, 3'b011, 1'b0, 8'd0, "R8");
        end
        drain();
        wait_mode = 0;
        busy_mode = 0;
        check(busy_seen > 0, "R8", $sformatf("busy cycles seen=%0d expected >0", busy_seen));
        check(q_addr.size() == 0, "R4", $sformatf("beats left=%0d expected 0", q_addr.size()));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule